// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block plays the keyboard end of a byte-oriented serial keyboard link. Bytes the host sends toward the keyboard arrive on a command strobe. Key events from a scanning front end arrive on a key strobe, with the scan code already translated. Each reply byte and each make or break code is pushed into a small circular queue. The host's receive path pops that queue one byte at a time.

Two commands answer with a canned reply that replaces whatever the queue held. A third command swallows the byte that follows it, which is the lamp setting, and that byte is never decoded. Two toggle-lock keys (caps and num) go through a press/release filter, so that each full on/off toggle of the key reaches the host as a single make and a single break.

Top module: `kbd_cmd_responder`

## Requirements
- R1: A synchronous reset empties the queue, drives `rx_avail` low and `rx_data` to 0x00, clears the pending lamp-byte skip, and returns both lock-key filter states to zero.
- R2: Command 0x01 discards the queue contents and leaves exactly 0xFF, 0x04, 0x7F queued, in that read order.
- R3: Command 0x07 or 0x0F discards the queue contents and leaves exactly 0xFE, 0x21 queued, in that read order.
- R4: Command 0x0E queues nothing and arms a skip. The next command byte is consumed as the lamp value and is not decoded, even if it is 0x01, 0x07, 0x0E or 0x0F. The skip is then cleared.
- R5: Any command byte other than 0x01, 0x07, 0x0E and 0x0F leaves the queue and `rx_avail` unchanged.
- R6: A key event with `key_release`=0 queues `key_code` unchanged. With `key_release`=1 it queues `key_code` with bit 7 forced to 1.
- R7: Each lock key has a 2-bit state. A press flips bit 0 and a release flips bit 1, and the event is dropped when the result is 2 (press) or 3 (release). Starting from reset, press, release, press, release therefore queues only the first press and the last release. `key_caps`=1 selects the caps state and `key_num`=1 selects the num state.
- R8: The queue holds at most 16 bytes. A key event that arrives while it is full is dropped, and the stored bytes are unchanged.
- R9: `rx_data` always shows the oldest queued byte, or 0x00 when the queue is empty. A read strobe pops that byte. A read on an empty queue changes nothing.
- R10: `rx_avail` rises when a byte is queued. After a read it is high exactly when bytes remain.
- R11: Read and write positions wrap at the queue depth, and first-in first-out order is kept across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A host command byte is present this cycle |
| cmd_byte | input | 8 | Host command byte |
| key_valid | input | 1 | A key event is present this cycle |
| key_release | input | 1 | 1 = release, 0 = press |
| key_caps | input | 1 | Event is the caps-lock key |
| key_num | input | 1 | Event is the num-lock key |
| key_code | input | 8 | Translated scan code |
| rd_en | input | 1 | Host pops the head byte |
| rx_avail | output | 1 | Queued data is available |
| rx_data | output | 8 | Head byte of the queue, 0x00 when empty |

## Verification
The assertions assume that at most one of `cmd_valid`, `key_valid` and `rd_en` is high in any cycle. They also assume that a key event never marks itself as both the caps and the num key. The design still resolves an overlap with read first, then command, then key, but the properties are written for exclusive strobes. The bench keeps within these assumptions by construction: every stimulus task raises exactly one strobe for one cycle and clears it before the next task starts.

// File: rtl/kbd_cmd_responder.sv
module kbd_cmd_responder #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       key_valid,
  input  logic       key_release,
  input  logic       key_caps,
  input  logic       key_num,
  input  logic [7:0] key_code,
  input  logic       rd_en,
  output logic       rx_avail,
  output logic [7:0] rx_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rptr, wptr;
  logic [CW-1:0] cnt;
  logic          skip;
  logic [1:0]    caps_st, num_st;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire empty    = (cnt == '0);
  wire full     = (cnt == CW'(DEPTH));
  wire cmd_go   = cmd_valid && !rd_en;
  wire cmd_live = cmd_go && !skip;
  wire do_reset = cmd_live && (cmd_byte == 8'h01);
  wire do_query = cmd_live && (cmd_byte == 8'h07 || cmd_byte == 8'h0F);
  wire do_led   = cmd_live && (cmd_byte == 8'h0E);

  wire       lock_key = key_caps || key_num;
  wire [1:0] lk_cur   = key_caps ? caps_st : num_st;
  wire [1:0] lk_nxt   = lk_cur ^ (key_release ? 2'b10 : 2'b01);
  wire       key_drop = lock_key && (key_release ? (lk_nxt == 2'b11) : (lk_nxt == 2'b10));
  wire       key_go   = key_valid && !rd_en && !cmd_valid;
  wire       key_push = key_go && !key_drop && !full;
  wire [7:0] key_byte = key_release ? (key_code | 8'h80) : key_code;

  assign rx_data = empty ? 8'h00 : mem[rptr];

  always_ff @(posedge clk) begin
    if (do_reset) begin
      mem[PW'(0)] <= 8'hFF;
      mem[PW'(1)] <= 8'h04;
      mem[PW'(2)] <= 8'h7F;
    end else if (do_query) begin
      mem[PW'(0)] <= 8'hFE;
      mem[PW'(1)] <= 8'h21;
    end else if (key_push) begin
      mem[wptr] <= key_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr     <= '0;
      wptr     <= '0;
      cnt      <= '0;
      skip     <= 1'b0;
      caps_st  <= 2'b00;
      num_st   <= 2'b00;
      rx_avail <= 1'b0;
    end else if (rd_en) begin
      if (!empty) begin
        rptr <= nxt(rptr);
        cnt  <= cnt - 1'b1;
      end
      rx_avail <= (cnt > CW'(1));
    end else if (do_reset) begin
      rptr     <= '0;
      wptr     <= PW'(3);
      cnt      <= CW'(3);
      rx_avail <= 1'b1;
    end else if (do_query) begin
      rptr     <= '0;
      wptr     <= PW'(2);
      cnt      <= CW'(2);
      rx_avail <= 1'b1;
    end else if (cmd_go) begin
      if (skip)        skip <= 1'b0;
      else if (do_led) skip <= 1'b1;
    end else if (key_go) begin
      if (key_caps)     caps_st <= lk_nxt;
      else if (key_num) num_st  <= lk_nxt;
      if (key_push) begin
        wptr     <= nxt(wptr);
        cnt      <= cnt + 1'b1;
        rx_avail <= 1'b1;
      end
    end
  end

  // input assumption: exclusive strobes
  input_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_valid, key_valid, rd_en}) && !(key_valid && key_caps && key_num));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R2
  reset_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !rd_en && !skip && cmd_byte == 8'h01
    |=> rx_data == 8'hFF && rx_avail && cnt == CW'(3));

  // R3
  query_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !rd_en && !skip && (cmd_byte == 8'h07 || cmd_byte == 8'h0F)
    |=> rx_data == 8'hFE && rx_avail && cnt == CW'(2));

  // R4
  led_skip_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !rd_en && skip |=> !skip && cnt == $past(cnt));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid && !cmd_valid && !rd_en && cnt == CW'(DEPTH) |=> cnt == CW'(DEPTH));

  // R9
  empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cnt == '0 |-> rx_data == 8'h00);

  // R10
  avail_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    rx_avail |-> cnt != '0);

  // R10
  reread_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && cnt > CW'(1) |=> rx_avail);
endmodule

// File: tb/kbd_cmd_responder_bench.sv
module kbd_cmd_responder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 0, key_valid = 0, key_release = 0, key_caps = 0, key_num = 0, rd_en = 0;
  logic [7:0] cmd_byte = 0, key_code = 0;
  logic rx_avail;
  logic [7:0] rx_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kbd_cmd_responder u_kbd_cmd_responder (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .key_valid(key_valid), .key_release(key_release), .key_caps(key_caps),
    .key_num(key_num), .key_code(key_code), .rd_en(rd_en),
    .rx_avail(rx_avail), .rx_data(rx_data));

  // entry: op[20:19] (0 cmd,1 press,2 release,3 read), lock[18:17] {num,caps},
  //        data[16:9], expected head[8:1], expected avail[0]
  localparam logic [20:0] VEC [21] = '{
    {2'd0, 2'b00, 8'h01, 8'hFF, 1'b1},  // R2
    {2'd3, 2'b00, 8'h00, 8'h04, 1'b1},  // R9
    {2'd0, 2'b00, 8'h05, 8'h04, 1'b1},  // R5
    {2'd1, 2'b00, 8'h1C, 8'h04, 1'b1},  // R6
    {2'd2, 2'b00, 8'h1C, 8'h04, 1'b1},  // R6
    {2'd0, 2'b00, 8'h0F, 8'hFE, 1'b1},  // R3
    {2'd0, 2'b00, 8'h0E, 8'hFE, 1'b1},  // R4
    {2'd0, 2'b00, 8'h01, 8'hFE, 1'b1},  // R4 swallowed
    {2'd0, 2'b00, 8'h07, 8'hFE, 1'b1},  // R3
    {2'd3, 2'b00, 8'h00, 8'h21, 1'b1},  // R10
    {2'd3, 2'b00, 8'h00, 8'h00, 1'b0},  // R10
    {2'd3, 2'b00, 8'h00, 8'h00, 1'b0},  // R9 empty
    {2'd1, 2'b01, 8'h77, 8'h77, 1'b1},  // R7
    {2'd2, 2'b01, 8'h77, 8'h77, 1'b1},  // R7 dropped
    {2'd1, 2'b01, 8'h77, 8'h77, 1'b1},  // R7 dropped
    {2'd2, 2'b01, 8'h77, 8'h77, 1'b1},  // R7 queued F7
    {2'd3, 2'b00, 8'h00, 8'hF7, 1'b1},  // R7
    {2'd1, 2'b10, 8'h62, 8'hF7, 1'b1},  // R7
    {2'd2, 2'b10, 8'h62, 8'hF7, 1'b1},  // R7 dropped
    {2'd3, 2'b00, 8'h00, 8'h62, 1'b1},  // R7
    {2'd3, 2'b00, 8'h00, 8'h00, 1'b0}   // R7
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [1:0] lk, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = (op == 2'd0); cmd_byte = d;
    key_valid = (op == 2'd1 || op == 2'd2); key_release = (op == 2'd2);
    key_caps = lk[0]; key_num = lk[1]; key_code = d;
    rd_en = (op == 2'd3);
    @(negedge clk);
    cmd_valid = 0; key_valid = 0; rd_en = 0; key_caps = 0; key_num = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 rx_data", rx_data, 8'h00);
    check("R1 rx_avail", {7'd0, rx_avail}, 8'h00);

    foreach (VEC[i]) begin
      step(VEC[i][20:19], VEC[i][18:17], VEC[i][16:9]);
      check($sformatf("R2-table entry %0d head", i), rx_data, VEC[i][8:1]);
      check($sformatf("R10 table entry %0d avail", i), {7'd0, rx_avail}, {7'd0, VEC[i][0]});
    end

    // R8 R11: fill beyond depth from a non-zero position, drain in order
    step(2'd1, 2'b00, 8'h55);
    step(2'd3, 2'b00, 8'h00);
    for (int i = 0; i < 17; i++) step(2'd1, 2'b00, 8'h10 + 8'(i));
    for (int i = 0; i < 16; i++) begin
      check("R11 order across wrap", rx_data, 8'h10 + 8'(i));
      check("R10 avail while data", {7'd0, rx_avail}, 8'h01);
      step(2'd3, 2'b00, 8'h00);
    end
    check("R8 extra byte dropped", rx_data, 8'h00);
    check("R10 avail low when drained", {7'd0, rx_avail}, 8'h00);

    // R1: reset clears skip and lock state
    step(2'd1, 2'b00, 8'h33);
    step(2'd0, 2'b00, 8'h0E);
    step(2'd1, 2'b01, 8'h58);
    step(2'd2, 2'b01, 8'h58);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 queue empty after reset", rx_data, 8'h00);
    check("R1 avail low after reset", {7'd0, rx_avail}, 8'h00);
    step(2'd0, 2'b00, 8'h01);
    check("R1 skip cleared by reset", rx_data, 8'hFF);
    step(2'd3, 2'b00, 8'h00);
    check("R2 second reply byte", rx_data, 8'h04);
    step(2'd3, 2'b00, 8'h00);
    check("R2 third reply byte", rx_data, 8'h7F);
    step(2'd3, 2'b00, 8'h00);
    step(2'd1, 2'b01, 8'h58);
    check("R1 lock state cleared by reset", rx_data, 8'h58);
    step(2'd0, 2'b00, 8'h42);
    check("R5 unknown command ignored", rx_data, 8'h58);
    step(2'd3, 2'b00, 8'h00);
    step(2'd3, 2'b00, 8'h00);
    check("R9 read on empty keeps zero", rx_data, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule